// File: doc/BRIEF.md
# Vector Lane Duplicate and Insert Unit

This unit rearranges the lanes of a 64-bit vector register in one clocked step. It can broadcast one 16-bit or 32-bit lane to every lane of the result. It can write a halfword or a word into one lane of a prior destination value and keep the remaining lanes. It can also move a word out to a scalar output, widen bytes to halfwords or halfwords to sign-extended words across two result vectors, narrow halfwords to bytes, and split or join a vector and a pair of 32-bit scalars.

The surrounding pipeline supplies the operation code, a 2-bit lane index, two vector sources, two scalar sources and the prior value of the destination register. It writes back the results one cycle later, when `out_valid` is high. If a lane index is out of range for the operation, or the code is undefined, the unit raises `illegal`. In that case the destination keeps its prior value, so writing back is harmless. Register files and instruction decode sit outside this unit.

Top module: `vlane_dupins`

## Requirements
- R1: Results are registered. An operation accepted with `in_valid` high appears on the outputs on the next rising edge, with `out_valid` high. While `in_valid` is low, `out_valid` is low and all other outputs hold their values. Synchronous reset clears every output to zero.
- R2: Code 0 (halfword broadcast) takes lane `lane_idx` of `vec_a`, where index 0 is bits 15:0 and index 3 is bits 63:48, and copies it into all four 16-bit lanes of `res_a`.
- R3: Code 1 (word broadcast) takes the low word of `vec_a` for index 0 or the high word for index 1, and copies it into both words of `res_a`.
- R4: Code 2 (halfword insert) writes `vec_a[15:0]` into lane `lane_idx` of `res_a`. Every other bit of `res_a` equals `dst_prev`.
- R5: Code 3 (word insert from vector) writes `vec_a[31:0]`, and code 4 (word insert from scalar) writes `scal_lo_in`. The word goes to the low word of `res_a` for index 0 or the high word for index 1. The other word equals `dst_prev`.
- R6: Code 5 (word extract) drives `scal_lo_out` with `vec_a[31:0]` for index 0 and with `vec_a[63:32]` for index 1.
- R7: Code 6 (byte to halfword) places bytes 0..3 of `vec_a`, zero-extended, in lanes 0..3 of `res_a`, and bytes 4..7 in lanes 0..3 of `res_b`.
- R8: Code 7 (halfword to byte) makes the low byte of halfword i of `vec_a` result byte i, and the low byte of halfword i of `vec_b` result byte i+4 of `res_a`, for i = 0..3.
- R9: Code 8 (halfword to word) sign-extends halfwords 0 and 1 of `vec_a` into the low and high words of `res_a`, and halfwords 2 and 3 into the low and high words of `res_b`.
- R10: Code 9 (split) drives `scal_lo_out` with `vec_a[31:0]` and `scal_hi_out` with `vec_a[63:32]`. Code 10 (join) sets `res_a` to `{scal_hi_in, scal_lo_in}`.
- R11: For codes 1, 3, 4 and 5, a `lane_idx` of 2 or 3 sets `illegal`. The result is then `res_a = dst_prev`, and `res_b`, `scal_lo_out` and `scal_hi_out` are zero.
- R12: Codes 11 to 15 are undefined. They set `illegal` and give the same outputs as in R11.
- R13: A legal operation clears `illegal`. Outputs that the operation does not write take these defaults: `res_a = dst_prev`, and `res_b` and both scalar outputs are zero. Codes 6 to 10 ignore `lane_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select |
| lane_idx | input | 2 | Lane index |
| vec_a | input | 64 | First vector source |
| vec_b | input | 64 | Second vector source |
| scal_lo_in | input | 32 | Scalar source, low word of a pair |
| scal_hi_in | input | 32 | Scalar source, high word of a pair |
| dst_prev | input | 64 | Prior destination value |
| out_valid | output | 1 | Results valid |
| res_a | output | 64 | First vector result |
| res_b | output | 64 | Second vector result |
| scal_lo_out | output | 32 | Scalar result, low word |
| scal_hi_out | output | 32 | Scalar result, high word |
| illegal | output | 1 | Index out of range or code undefined |

## Verification
The bench drives every lane index of the halfword broadcast and insert operations. A design with a wrong lane offset or a reversed lane order would copy or overwrite the wrong 16 bits. Word operations run with index 2 and 3, and undefined codes are issued. A design that folds the index to one bit, or lets an illegal result through, would write a broadcast word instead of keeping `dst_prev`. The widening tests use negative halfwords and bytes with the top bit set. A design that confused sign extension with zero extension would fill the upper bits with the wrong value. Last, inputs change while `in_valid` is low, which exposes outputs that are not held.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
    localparam int VEC_W  = 64;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int N_HALF = VEC_W / HALF_W;
    localparam int N_WORD = VEC_W / WORD_W;
    localparam int IDX_W  = $clog2(N_HALF);
    localparam int OP_W   = 4;

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [OP_W-1:0] {
        OP_DUP_H   = 4'd0,
        OP_DUP_W   = 4'd1,
        OP_INS_H   = 4'd2,
        OP_INS_W_V = 4'd3,
        OP_INS_W_S = 4'd4,
        OP_EXT_W   = 4'd5,
        OP_B2H     = 4'd6,
        OP_H2B     = 4'd7,
        OP_H2W     = 4'd8,
        OP_SPLIT   = 4'd9,
        OP_JOIN    = 4'd10
    } vl_op_e;

    typedef struct packed {
        vec_t  res_a;
        vec_t  res_b;
        word_t scal_lo;
        word_t scal_hi;
        logic  illegal;
    } vl_result_t;

    function automatic logic is_word_indexed(vl_op_e op);
        return (op == OP_DUP_W) || (op == OP_INS_W_V) ||
               (op == OP_INS_W_S) || (op == OP_EXT_W);
    endfunction

    function automatic logic is_defined(logic [OP_W-1:0] code);
        return code <= OP_JOIN;
    endfunction

    function automatic word_t sext_half(logic [HALF_W-1:0] h);
        return {{(WORD_W-HALF_W){h[HALF_W-1]}}, h};
    endfunction
endpackage

// File: rtl/vlane_idx_check.sv
module vlane_idx_check
    import vlane_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    input  idx_t            lane_idx,
    output logic            bad
);
    vl_op_e op;
    assign op = vl_op_e'(op_code);

    always_comb begin
        if (!is_defined(op_code))
            bad = 1'b1;
        else if (is_word_indexed(op))
            bad = (int'(lane_idx) >= N_WORD);
        else
            bad = 1'b0;
    end
endmodule

// File: rtl/vlane_sel.sv
module vlane_sel
    import vlane_pkg::*;
(
    input  vl_op_e op,
    input  idx_t   lane_idx,
    input  vec_t   vec_a,
    input  word_t  scal_lo_in,
    input  vec_t   dst_prev,
    output vec_t   dup_h,
    output vec_t   dup_w,
    output vec_t   ins_h,
    output vec_t   ins_w,
    output word_t  ext_w
);
    logic [HALF_W-1:0] halves [N_HALF];
    word_t             words  [N_WORD];
    logic [HALF_W-1:0] pick_h;
    word_t             pick_w;
    word_t             ins_src;
    logic [$clog2(N_WORD > 1 ? N_WORD : 2)-1:0] widx;

    for (genvar g = 0; g < N_HALF; g++) begin : g_hsplit
        assign halves[g] = vec_a[g*HALF_W +: HALF_W];
    end
    for (genvar g = 0; g < N_WORD; g++) begin : g_wsplit
        assign words[g] = vec_a[g*WORD_W +: WORD_W];
    end

    assign widx    = lane_idx[$bits(widx)-1:0];
    assign pick_h  = halves[lane_idx];
    assign pick_w  = words[widx];
    assign ext_w   = pick_w;
    assign ins_src = (op == OP_INS_W_S) ? scal_lo_in : words[0];

    for (genvar g = 0; g < N_HALF; g++) begin : g_hlane
        assign dup_h[g*HALF_W +: HALF_W] = pick_h;
        assign ins_h[g*HALF_W +: HALF_W] = (int'(lane_idx) == g) ? halves[0]
                                          : dst_prev[g*HALF_W +: HALF_W];
    end
    for (genvar g = 0; g < N_WORD; g++) begin : g_wlane
        assign dup_w[g*WORD_W +: WORD_W] = pick_w;
        assign ins_w[g*WORD_W +: WORD_W] = (int'(widx) == g) ? ins_src
                                          : dst_prev[g*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/vlane_pack.sv
module vlane_pack
    import vlane_pkg::*;
(
    input  vec_t vec_a,
    input  vec_t vec_b,
    output vec_t b2h_lo,
    output vec_t b2h_hi,
    output vec_t h2b,
    output vec_t h2w_lo,
    output vec_t h2w_hi
);
    localparam int HALF_BYTES = N_HALF;

    for (genvar i = 0; i < N_HALF; i++) begin : g_bytes
        assign b2h_lo[i*HALF_W +: HALF_W] =
            {{(HALF_W-BYTE_W){1'b0}}, vec_a[i*BYTE_W +: BYTE_W]};
        assign b2h_hi[i*HALF_W +: HALF_W] =
            {{(HALF_W-BYTE_W){1'b0}}, vec_a[(i+HALF_BYTES)*BYTE_W +: BYTE_W]};
        assign h2b[i*BYTE_W +: BYTE_W]              = vec_a[i*HALF_W +: BYTE_W];
        assign h2b[(i+HALF_BYTES)*BYTE_W +: BYTE_W] = vec_b[i*HALF_W +: BYTE_W];
    end

    for (genvar w = 0; w < N_WORD; w++) begin : g_words
        assign h2w_lo[w*WORD_W +: WORD_W] = sext_half(vec_a[w*HALF_W +: HALF_W]);
        assign h2w_hi[w*WORD_W +: WORD_W] =
            sext_half(vec_a[(w+N_WORD)*HALF_W +: HALF_W]);
    end
endmodule

// File: rtl/vlane_dupins.sv
module vlane_dupins
    import vlane_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  op_code,
    input  logic [1:0]  lane_idx,
    input  logic [63:0] vec_a,
    input  logic [63:0] vec_b,
    input  logic [31:0] scal_lo_in,
    input  logic [31:0] scal_hi_in,
    input  logic [63:0] dst_prev,
    output logic        out_valid,
    output logic [63:0] res_a,
    output logic [63:0] res_b,
    output logic [31:0] scal_lo_out,
    output logic [31:0] scal_hi_out,
    output logic        illegal
);
    vl_op_e     op;
    logic       bad;
    vec_t       dup_h, dup_w, ins_h, ins_w;
    word_t      ext_w;
    vec_t       b2h_lo, b2h_hi, h2b, h2w_lo, h2w_hi;
    vl_result_t nxt, cur;

    assign op = vl_op_e'(op_code);

    vlane_idx_check u_idx (
        .op_code (op_code),
        .lane_idx(lane_idx),
        .bad     (bad)
    );

    vlane_sel u_sel (
        .op        (op),
        .lane_idx  (lane_idx),
        .vec_a     (vec_a),
        .scal_lo_in(scal_lo_in),
        .dst_prev  (dst_prev),
        .dup_h     (dup_h),
        .dup_w     (dup_w),
        .ins_h     (ins_h),
        .ins_w     (ins_w),
        .ext_w     (ext_w)
    );

    vlane_pack u_pack (
        .vec_a (vec_a),
        .vec_b (vec_b),
        .b2h_lo(b2h_lo),
        .b2h_hi(b2h_hi),
        .h2b   (h2b),
        .h2w_lo(h2w_lo),
        .h2w_hi(h2w_hi)
    );

    always_comb begin
        nxt         = '0;
        nxt.res_a   = dst_prev;
        nxt.illegal = bad;
        if (!bad) begin
            case (op)
                OP_DUP_H:   nxt.res_a = dup_h;
                OP_DUP_W:   nxt.res_a = dup_w;
                OP_INS_H:   nxt.res_a = ins_h;
                OP_INS_W_V,
                OP_INS_W_S: nxt.res_a = ins_w;
                OP_EXT_W:   nxt.scal_lo = ext_w;
                OP_B2H: begin
                    nxt.res_a = b2h_lo;
                    nxt.res_b = b2h_hi;
                end
                OP_H2B:     nxt.res_a = h2b;
                OP_H2W: begin
                    nxt.res_a = h2w_lo;
                    nxt.res_b = h2w_hi;
                end
                OP_SPLIT: begin
                    nxt.scal_lo = vec_a[WORD_W-1:0];
                    nxt.scal_hi = vec_a[VEC_W-1:WORD_W];
                end
                OP_JOIN:    nxt.res_a = {scal_hi_in, scal_lo_in};
                default:    nxt.res_a = dst_prev;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                cur <= nxt;
        end
    end

    assign res_a       = cur.res_a;
    assign res_b       = cur.res_b;
    assign scal_lo_out = cur.scal_lo;
    assign scal_hi_out = cur.scal_hi;
    assign illegal     = cur.illegal;
endmodule

// File: rtl/vlane_dupins_chk.sv
module vlane_dupins_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  op_code,
    input logic [1:0]  lane_idx,
    input logic [63:0] vec_a,
    input logic [63:0] vec_b,
    input logic [31:0] scal_lo_in,
    input logic [31:0] scal_hi_in,
    input logic [63:0] dst_prev,
    input logic        out_valid,
    input logic [63:0] res_a,
    input logic [63:0] res_b,
    input logic [31:0] scal_lo_out,
    input logic [31:0] scal_hi_out,
    input logic        illegal
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res_a) && $stable(res_b) &&
                       $stable(scal_lo_out) && $stable(illegal)));

    p_dup_lanes_equal_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd0) |=>
        (res_a[15:0] == res_a[31:16] && res_a[15:0] == res_a[47:32] &&
         res_a[15:0] == res_a[63:48]));

    p_ins_keeps_rest_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd2 && lane_idx == 2'd0) |=>
        (res_a[63:16] == $past(dst_prev[63:16]) &&
         res_a[15:0] == $past(vec_a[15:0])));

    p_b2h_zero_top_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd6) |=>
        (res_a[15:8] == 8'h00 && res_b[63:56] == 8'h00));

    p_join_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd10) |=>
        (res_a == {$past(scal_hi_in), $past(scal_lo_in)}));

    p_bad_word_idx_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd1 && lane_idx[1]) |=>
        (illegal && res_a == $past(dst_prev) && res_b == 64'd0));

    p_undef_code_r12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code > 4'd10) |=>
        (illegal && res_a == $past(dst_prev) && scal_hi_out == 32'd0));
endmodule

bind vlane_dupins vlane_dupins_chk u_chk (.*);

// File: tb/tb_vlane_dupins.sv
`timescale 1ns/1ps
module tb_vlane_dupins;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op_code;
    logic [1:0]  lane_idx;
    logic [63:0] vec_a, vec_b, dst_prev;
    logic [31:0] scal_lo_in, scal_hi_in;
    logic        out_valid;
    logic [63:0] res_a, res_b;
    logic [31:0] scal_lo_out, scal_hi_out;
    logic        illegal;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vlane_dupins dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [3:0] op, input logic [1:0] idx,
        input logic [63:0] a, input logic [63:0] b, input logic [31:0] sl,
        input logic [31:0] sh, input logic [63:0] prev,
        output logic [63:0] ra, output logic [63:0] rb,
        output logic [31:0] so_l, output logic [31:0] so_h, output logic ill);
        ra = prev; rb = '0; so_l = '0; so_h = '0; ill = 1'b0;
        case (op)
            4'd0: ra = {4{a[16*idx +: 16]}};
            4'd1: if (idx > 1) ill = 1'b1; else ra = {2{a[32*idx +: 32]}};
            4'd2: ra[16*idx +: 16] = a[15:0];
            4'd3: if (idx > 1) ill = 1'b1; else ra[32*idx +: 32] = a[31:0];
            4'd4: if (idx > 1) ill = 1'b1; else ra[32*idx +: 32] = sl;
            4'd5: if (idx > 1) ill = 1'b1; else so_l = a[32*idx +: 32];
            4'd6: for (int i = 0; i < 4; i++) begin
                      ra[16*i +: 16] = {8'h00, a[8*i +: 8]};
                      rb[16*i +: 16] = {8'h00, a[8*(i+4) +: 8]};
                  end
            4'd7: for (int i = 0; i < 4; i++) begin
                      ra[8*i +: 8]     = a[16*i +: 8];
                      ra[8*(i+4) +: 8] = b[16*i +: 8];
                  end
            4'd8: begin
                      ra = {{16{a[31]}}, a[31:16], {16{a[15]}}, a[15:0]};
                      rb = {{16{a[63]}}, a[63:48], {16{a[47]}}, a[47:32]};
                  end
            4'd9: begin so_l = a[31:0]; so_h = a[63:32]; end
            4'd10: ra = {sh, sl};
            default: ill = 1'b1;
        endcase
        if (ill) ra = prev;
    endfunction

    logic [63:0] e_ra, e_rb;
    logic [31:0] e_sl, e_sh;
    logic        e_ill;

    task automatic issue(input string req, input logic [3:0] op, input logic [1:0] idx,
        input logic [63:0] a, input logic [63:0] b, input logic [31:0] sl,
        input logic [31:0] sh, input logic [63:0] prev);
        model(op, idx, a, b, sl, sh, prev, e_ra, e_rb, e_sl, e_sh, e_ill);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; lane_idx = idx; vec_a = a; vec_b = b;
        scal_lo_in = sl; scal_hi_in = sh; dst_prev = prev;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " res_a"}, res_a, e_ra);
        check({req, " res_b"}, res_b, e_rb);
        check({req, " scal_lo"}, {32'd0, scal_lo_out}, {32'd0, e_sl});
        check({req, " scal_hi"}, {32'd0, scal_hi_out}, {32'd0, e_sh});
        check({req, " illegal"}, {63'd0, illegal}, {63'd0, e_ill});
        check({req, " out_valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    localparam logic [63:0] A0 = 64'h8899_AABB_CCDD_EEFF;
    localparam logic [63:0] A1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] P0 = 64'h5555_6666_7777_8888;

    task automatic t_reset_r1();
        check("R1 reset res_a", res_a, 64'd0);
        check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset illegal", {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_dup_r2_r3();
        for (int i = 0; i < 4; i++) issue("R2 dup half", 4'd0, 2'(i), A1, 64'd0, 32'd0, 32'd0, P0);
        issue("R3 dup word lo", 4'd1, 2'd0, A1, 64'd0, 32'd0, 32'd0, P0);
        issue("R3 dup word hi", 4'd1, 2'd1, A0, 64'd0, 32'd0, 32'd0, P0);
    endtask

    task automatic t_insert_r4_r5();
        for (int i = 0; i < 4; i++) issue("R4 ins half", 4'd2, 2'(i), 64'h0000_0000_0000_BEEF, 64'd0, 32'd0, 32'd0, P0);
        issue("R5 ins word vec", 4'd3, 2'd1, A1, 64'd0, 32'd0, 32'd0, P0);
        issue("R5 ins word vec lo", 4'd3, 2'd0, A0, 64'd0, 32'd0, 32'd0, P0);
        issue("R5 ins word scal", 4'd4, 2'd1, A1, 64'd0, 32'hDEAD_F00D, 32'd0, P0);
        issue("R5 ins word scal lo", 4'd4, 2'd0, A1, 64'd0, 32'h1357_9BDF, 32'd0, P0);
    endtask

    task automatic t_extract_r6();
        issue("R6 extract lo", 4'd5, 2'd0, A0, 64'd0, 32'd0, 32'd0, P0);
        issue("R6 extract hi", 4'd5, 2'd1, A0, 64'd0, 32'd0, 32'd0, P0);
    endtask

    task automatic t_pack_r7_r8_r9();
        issue("R7 byte to half", 4'd6, 2'd3, A0, 64'd0, 32'd0, 32'd0, P0);
        issue("R8 half to byte", 4'd7, 2'd0, A0, A1, 32'd0, 32'd0, P0);
        issue("R9 half to word neg", 4'd8, 2'd2, A0, 64'd0, 32'd0, 32'd0, P0);
        issue("R9 half to word mix", 4'd8, 2'd0, 64'h7FFF_8000_0001_FFFF, 64'd0, 32'd0, 32'd0, P0);
    endtask

    task automatic t_pair_r10();
        issue("R10 split", 4'd9, 2'd1, A1, 64'd0, 32'd0, 32'd0, P0);
        issue("R10 join", 4'd10, 2'd3, 64'd0, 64'd0, 32'hCAFE_0001, 32'hFACE_0002, P0);
    endtask

    task automatic t_illegal_r11_r12();
        issue("R11 dup word idx2", 4'd1, 2'd2, A0, 64'd0, 32'd0, 32'd0, P0);
        issue("R11 ins word idx3", 4'd4, 2'd3, A0, 64'd0, 32'h1111_2222, 32'd0, P0);
        issue("R11 extract idx2", 4'd5, 2'd2, A0, 64'd0, 32'd0, 32'd0, A1);
        issue("R12 undefined 11", 4'd11, 2'd0, A0, A1, 32'd1, 32'd2, P0);
        issue("R12 undefined 15", 4'd15, 2'd1, A0, A1, 32'd1, 32'd2, A1);
        issue("R13 legal after illegal", 4'd0, 2'd1, A0, 64'd0, 32'd0, 32'd0, P0);
    endtask

    task automatic t_hold_r1();
        issue("R1 before hold", 4'd8, 2'd0, A0, 64'd0, 32'd0, 32'd0, P0);
        @(negedge clk);
        op_code = 4'd10; vec_a = A1; scal_lo_in = 32'hFFFF_FFFF; dst_prev = 64'd0;
        @(negedge clk);
        check("R1 hold res_a", res_a, e_ra);
        check("R1 hold res_b", res_b, e_rb);
        check("R1 hold out_valid low", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_code = '0; lane_idx = '0;
        vec_a = '0; vec_b = '0; scal_lo_in = '0; scal_hi_in = '0; dst_prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_dup_r2_r3();
        t_insert_r4_r5();
        t_extract_r6();
        t_pack_r7_r8_r9();
        t_pair_r10();
        t_illegal_r11_r12();
        t_hold_r1();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule